// File: doc/BRIEF.md
# Pixel FIFO with Panic Hysteresis

This block buffers pixel words between a memory fetch engine and a display scan engine. The fetch side pushes words through a valid/ready port. The scan side pops them with a single read strobe, and the oldest word is always presented on the read data output. The block reports its occupancy as an entry count.

Two control outputs come from the occupancy. The first is a start permit for the scan engine. It rises once the buffer holds at least a programmed pre-fill number of entries. It stays up until the next frame start pulse withdraws it, so the buffer must pre-fill again for each frame.

The second is a bus-priority request. It rises when occupancy drops under a low watermark and falls only when occupancy climbs over a high watermark. When its enable input is low, the request is held low. A strobe issued while the buffer is empty is recorded in a sticky underrun flag, which a one-cycle clear pulse resets. Watermarks and the pre-fill level are 10-bit entry counts. Setting the low watermark above the high watermark is not a supported configuration.

Top module: `pix_stream_fifo`

## Requirements
- R1: `level` equals accepted writes minus successful reads. A cycle that both accepts a write and pops a word leaves `level` unchanged.
- R2: Words leave in the order they were accepted. `rd_data` shows the oldest stored word in the same cycle, and `rd_en` removes that word at the next clock edge.
- R3: `wr_ready` is low exactly when `level` equals DEPTH. A `wr_valid` raised while `wr_ready` is low stores nothing and leaves `level` unchanged.
- R4: With `panic_en` high, an edge at which `level < cfg_low` makes `panic` high from that edge on.
- R5: With `panic_en` high, an edge at which `level > cfg_high` (and `level >= cfg_low`) makes `panic` low from that edge on.
- R6: While `cfg_low <= level <= cfg_high`, `panic` keeps its previous value. Both bounds are inclusive.
- R7: An edge at which `panic_en` is low drives `panic` low, whatever the occupancy.
- R8: An edge at which `level >= cfg_prefill` and `frame_start` is low sets `prefill_done`. Once set, it stays high while words are read out.
- R9: An edge with `frame_start` high clears `prefill_done`. If `level` still meets the pre-fill level, the flag sets again at the following edge.
- R10: `rd_en` while `level` is 0 pops nothing, keeps `level` at 0, and sets `underrun` at that edge. `underrun` then stays high.
- R11: `underrun_clr` clears `underrun` at the next edge. When a new empty read arrives in the same cycle, the set wins.
- R12: While `rst` is high, `level`, `panic`, `prefill_done` and `underrun` are 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request from the fetch side |
| wr_ready | output | 1 | Buffer can accept a word |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Pop strobe from the scan side |
| rd_data | output | DATA_W | Oldest stored word |
| level | output | $clog2(DEPTH+1) | Current occupancy in entries |
| cfg_low | input | 10 | Low watermark for the priority request |
| cfg_high | input | 10 | High watermark for the priority request |
| cfg_prefill | input | 10 | Occupancy that grants the scan start permit |
| panic_en | input | 1 | Enables the priority request |
| frame_start | input | 1 | Pulse at each new frame; withdraws the start permit |
| underrun_clr | input | 1 | Clear pulse for the underrun flag |
| prefill_done | output | 1 | Scan start permit |
| panic | output | 1 | Bus-priority request with hysteresis |
| underrun | output | 1 | Sticky empty-read flag |

## Verification
The bench builds the buffer with DEPTH set to 16 and DATA_W set to 16. This lets a few dozen pushes reach the full boundary, where writes are refused. It also lets the occupancy swing across a low watermark of 4 and a high watermark of 10 in both directions, including stops exactly on each watermark. With that depth, the pre-fill threshold of 5 and the empty-read and clear races can be hit directly. Every popped word is checked against an ordered model.

// File: rtl/pix_stream_pkg.sv
package pix_stream_pkg;

    // Watermark and pre-fill fields are fixed at 10 bits of entry count.
    localparam int PSF_LVL_W = 10;

    typedef logic [PSF_LVL_W-1:0] psf_lvl_t;

    typedef struct packed {
        psf_lvl_t low;
        psf_lvl_t high;
        psf_lvl_t prefill;
    } psf_thresh_t;

    typedef enum logic [1:0] {
        PSF_HYS_HOLD  = 2'd0,
        PSF_HYS_RAISE = 2'd1,
        PSF_HYS_DROP  = 2'd2,
        PSF_HYS_OFF   = 2'd3
    } psf_hys_e;

    // Decision for the priority request. The enable wins, then the under-low test.
    function automatic psf_hys_e psf_hys_decide(input logic en, input logic below, input logic above);
        if (!en)
            return PSF_HYS_OFF;
        else if (below)
            return PSF_HYS_RAISE;
        else if (above)
            return PSF_HYS_DROP;
        else
            return PSF_HYS_HOLD;
    endfunction

    function automatic int psf_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psf_ring.sv
module psf_ring #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push)
                wptr <= bump(wptr);
            if (pop)
                rptr <= bump(rptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/psf_panic.sv
module psf_panic
    import pix_stream_pkg::*;
#(
    parameter int CW     = 11,
    localparam int CMP_W = psf_max(CW, PSF_LVL_W)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic [CW-1:0] count,
    input  psf_lvl_t low,
    input  psf_lvl_t high,
    output logic     panic
);

    logic     below, above;
    psf_hys_e act;

    assign below = CMP_W'(count) < CMP_W'(low);
    assign above = CMP_W'(count) > CMP_W'(high);
    assign act   = psf_hys_decide(en, below, above);

    always_ff @(posedge clk) begin
        if (rst) begin
            panic <= 1'b0;
        end else begin
            unique case (act)
                PSF_HYS_RAISE: panic <= 1'b1;
                PSF_HYS_DROP:  panic <= 1'b0;
                PSF_HYS_OFF:   panic <= 1'b0;
                default:       panic <= panic;
            endcase
        end
    end

endmodule

// File: rtl/psf_gate.sv
module psf_gate
    import pix_stream_pkg::*;
#(
    parameter int CW     = 11,
    localparam int CMP_W = psf_max(CW, PSF_LVL_W)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic [CW-1:0] count,
    input  psf_lvl_t prefill,
    input  logic     frame_start,
    input  logic     empty_read,
    input  logic     clr,
    output logic     ready_to_scan,
    output logic     miss_flag
);

    logic reached;

    assign reached = CMP_W'(count) >= CMP_W'(prefill);

    // Start permit: a frame start withdraws it; otherwise it latches once reached.
    always_ff @(posedge clk) begin
        if (rst)
            ready_to_scan <= 1'b0;
        else if (frame_start)
            ready_to_scan <= 1'b0;
        else if (reached)
            ready_to_scan <= 1'b1;
    end

    // Sticky miss flag: a new event takes priority over the clear pulse.
    always_ff @(posedge clk) begin
        if (rst)
            miss_flag <= 1'b0;
        else if (empty_read)
            miss_flag <= 1'b1;
        else if (clr)
            miss_flag <= 1'b0;
    end

endmodule

// File: rtl/pix_stream_fifo.sv
module pix_stream_fifo
    import pix_stream_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     level,
    input  logic [PSF_LVL_W-1:0] cfg_low,
    input  logic [PSF_LVL_W-1:0] cfg_high,
    input  logic [PSF_LVL_W-1:0] cfg_prefill,
    input  logic              panic_en,
    input  logic              frame_start,
    input  logic              underrun_clr,
    output logic              prefill_done,
    output logic              panic,
    output logic              underrun
);

    psf_thresh_t th;
    logic        full, empty, push, pop, empty_read;

    assign th.low     = cfg_low;
    assign th.high    = cfg_high;
    assign th.prefill = cfg_prefill;

    assign wr_ready   = !full;
    assign push       = wr_valid && !full;
    assign pop        = rd_en && !empty;
    assign empty_read = rd_en && empty;

    psf_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ring_i (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (wr_data),
        .dout  (rd_data),
        .count (level),
        .full  (full),
        .empty (empty)
    );

    psf_panic #(.CW(CW)) panic_i (
        .clk   (clk),
        .rst   (rst),
        .en    (panic_en),
        .count (level),
        .low   (th.low),
        .high  (th.high),
        .panic (panic)
    );

    psf_gate #(.CW(CW)) gate_i (
        .clk           (clk),
        .rst           (rst),
        .count         (level),
        .prefill       (th.prefill),
        .frame_start   (frame_start),
        .empty_read    (empty_read),
        .clr           (underrun_clr),
        .ready_to_scan (prefill_done),
        .miss_flag     (underrun)
    );

endmodule

// File: rtl/pix_stream_fifo_chk.sv
module pix_stream_fifo_chk
    import pix_stream_pkg::*;
#(
    parameter int DEPTH  = 1024,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int CMP_W = psf_max(CW, PSF_LVL_W)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_valid,
    input logic                 wr_ready,
    input logic                 rd_en,
    input logic [CW-1:0]        level,
    input logic [PSF_LVL_W-1:0] cfg_low,
    input logic [PSF_LVL_W-1:0] cfg_high,
    input logic [PSF_LVL_W-1:0] cfg_prefill,
    input logic                 panic_en,
    input logic                 frame_start,
    input logic                 underrun_clr,
    input logic                 prefill_done,
    input logic                 panic,
    input logic                 underrun
);

    logic lo_hit, hi_hit, pf_hit, empty_rd;

    assign lo_hit   = CMP_W'(level) < CMP_W'(cfg_low);
    assign hi_hit   = CMP_W'(level) > CMP_W'(cfg_high);
    assign pf_hit   = CMP_W'(level) >= CMP_W'(cfg_prefill);
    assign empty_rd = rd_en && (level == '0);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    assert_full_refuses_R3: assert property (@(posedge clk) disable iff (rst)
        (level == CW'(DEPTH)) |-> !wr_ready);

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (level == CW'(DEPTH) && !rd_en) |=> (level == CW'(DEPTH)));

    assert_panic_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (panic_en && lo_hit) |=> panic);

    assert_panic_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (hi_hit && !lo_hit) |=> !panic);

    assert_panic_off_R7: assert property (@(posedge clk) disable iff (rst)
        !panic_en |=> !panic);

    assert_prefill_set_R8: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && pf_hit) |=> prefill_done);

    assert_prefill_clear_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !prefill_done);

    assert_underrun_set_R10: assert property (@(posedge clk) disable iff (rst)
        empty_rd |=> underrun);

    assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (empty_rd && !wr_valid) |=> (level == '0));

    assert_underrun_clr_R11: assert property (@(posedge clk) disable iff (rst)
        (underrun_clr && !empty_rd) |=> !underrun);

endmodule

bind pix_stream_fifo pix_stream_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .rd_en        (rd_en),
    .level        (level),
    .cfg_low      (cfg_low),
    .cfg_high     (cfg_high),
    .cfg_prefill  (cfg_prefill),
    .panic_en     (panic_en),
    .frame_start  (frame_start),
    .underrun_clr (underrun_clr),
    .prefill_done (prefill_done),
    .panic        (panic),
    .underrun     (underrun)
);

// File: tb/pix_stream_fifo_tb_top.sv
module pix_stream_fifo_tb_top;

    localparam int DW = 16;
    localparam int DP = 16;
    localparam int CW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid, wr_ready, rd_en;
    logic [DW-1:0] wr_data, rd_data;
    logic [CW-1:0] level;
    logic [9:0]    cfg_low, cfg_high, cfg_prefill;
    logic          panic_en, frame_start, underrun_clr;
    logic          prefill_done, panic, underrun;

    always #5 clk = ~clk;

    pix_stream_fifo #(.DATA_W(DW), .DEPTH(DP)) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .level(level),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_prefill(cfg_prefill),
        .panic_en(panic_en), .frame_start(frame_start), .underrun_clr(underrun_clr),
        .prefill_done(prefill_done), .panic(panic), .underrun(underrun)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    // Ordered reference model of the stored words.
    logic [DW-1:0] model [DP];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    logic [DW-1:0] next_val = 16'h0100;

    // Vector table: pushes, pops, expected level, expected panic (low=4, high=10).
    typedef struct packed {
        logic [4:0] n_push;
        logic [4:0] n_pop;
        logic [4:0] exp_lvl;
        logic       exp_pan;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{5'd6,  5'd0,  5'd6,  1'b1},
        '{5'd5,  5'd0,  5'd11, 1'b0},
        '{5'd0,  5'd3,  5'd8,  1'b0},
        '{5'd0,  5'd5,  5'd3,  1'b1},
        '{5'd7,  5'd0,  5'd10, 1'b1},
        '{5'd1,  5'd0,  5'd11, 1'b0},
        '{5'd0,  5'd7,  5'd4,  1'b0},
        '{5'd0,  5'd1,  5'd3,  1'b1},
        '{5'd13, 5'd0,  5'd16, 1'b0},
        '{5'd0,  5'd16, 5'd0,  1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_valid = 1'b0; rd_en = 1'b0; frame_start = 1'b0; underrun_clr = 1'b0;
    endtask

    task automatic do_push(input logic [DW-1:0] v);
        @(negedge clk);
        rd_en = 1'b0; frame_start = 1'b0; underrun_clr = 1'b0;
        wr_valid = 1'b1; wr_data = v;
        if (wr_ready) begin
            model[m_tail] = v; m_tail = (m_tail + 1) % DP; m_cnt++;
        end
    endtask

    task automatic do_pop();
        @(negedge clk);
        wr_valid = 1'b0; frame_start = 1'b0; underrun_clr = 1'b0;
        rd_en = 1'b1;
        if (m_cnt > 0) begin
            check("R2 order", rd_data, model[m_head]);
            m_head = (m_head + 1) % DP; m_cnt--;
        end
    endtask

    task automatic do_both(input logic [DW-1:0] v);
        @(negedge clk);
        frame_start = 1'b0; underrun_clr = 1'b0;
        wr_valid = 1'b1; wr_data = v; rd_en = 1'b1;
        check("R2 order dual", rd_data, model[m_head]);
        m_head = (m_head + 1) % DP; m_cnt--;
        model[m_tail] = v; m_tail = (m_tail + 1) % DP; m_cnt++;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_data = '0; rd_en = 1'b0;
        cfg_low = 10'd4; cfg_high = 10'd10; cfg_prefill = 10'd5;
        panic_en = 1'b1; frame_start = 1'b0; underrun_clr = 1'b0;

        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12 level", level, 0);
        check("R12 wr_ready", wr_ready, 1);
        check("R12 panic", panic, 0);
        check("R12 prefill_done", prefill_done, 0);
        check("R12 underrun", underrun, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R4 empty raises panic", panic, 1);

        // R7 enable forces low
        panic_en = 1'b0;
        @(negedge clk);
        check("R7 panic off", panic, 0);
        panic_en = 1'b1;
        @(negedge clk);
        check("R4 panic back", panic, 1);

        // Table walk: R1, R4, R5, R6
        for (int i = 0; i < 10; i++) begin
            for (int k = 0; k < int'(VECS[i].n_push); k++) begin
                do_push(next_val); next_val++;
            end
            for (int k = 0; k < int'(VECS[i].n_pop); k++)
                do_pop();
            idle();
            idle();
            check($sformatf("R1 level vec%0d", i), level, VECS[i].exp_lvl);
            check($sformatf("R4/R5/R6 panic vec%0d", i), panic, VECS[i].exp_pan);
        end

        // R3 full refusal
        for (int k = 0; k < DP; k++) begin
            do_push(next_val); next_val++;
        end
        idle();
        check("R3 wr_ready full", wr_ready, 0);
        do_push(16'hDEAD);
        idle();
        check("R3 level held", level, DP);
        for (int k = 0; k < DP; k++)
            do_pop();
        idle();
        check("R1 drained", level, 0);

        // R1 simultaneous read and write
        for (int k = 0; k < 3; k++) begin
            do_push(next_val); next_val++;
        end
        do_both(next_val); next_val++;
        do_both(next_val); next_val++;
        idle();
        check("R1 dual level", level, 3);
        for (int k = 0; k < 3; k++)
            do_pop();
        idle();

        // R10 / R11 underrun
        check("R10 pre", underrun, 0);
        do_pop();
        idle();
        check("R10 underrun set", underrun, 1);
        check("R10 level stays 0", level, 0);
        repeat (3) idle();
        check("R10 sticky", underrun, 1);
        @(negedge clk); underrun_clr = 1'b1;
        idle();
        check("R11 cleared", underrun, 0);
        @(negedge clk); underrun_clr = 1'b1; rd_en = 1'b1;
        idle();
        check("R11 set wins", underrun, 1);
        @(negedge clk); underrun_clr = 1'b1;
        idle();
        check("R11 cleared again", underrun, 0);

        // R8 / R9 pre-fill permit
        @(negedge clk); frame_start = 1'b1;
        idle();
        check("R9 cleared by frame", prefill_done, 0);
        for (int k = 0; k < 4; k++) begin
            do_push(next_val); next_val++;
        end
        idle(); idle();
        check("R8 below prefill", prefill_done, 0);
        do_push(next_val); next_val++;
        idle();
        check("R8 lag one cycle", prefill_done, 0);
        idle();
        check("R8 reached", prefill_done, 1);
        @(negedge clk); frame_start = 1'b1;
        idle();
        check("R9 frame clears", prefill_done, 0);
        idle();
        check("R9 resets when still met", prefill_done, 1);
        for (int k = 0; k < 5; k++)
            do_pop();
        idle(); idle();
        check("R8 sticky after drain", prefill_done, 1);
        check("R1 final level", level, 0);

        finish_run();
    end

endmodule